// File: doc/BRIEF.md
# Strobed Nonvolatile Memory Bus Host Controller

This block is a synchronous host controller. It turns single-byte read and write requests into cycles on a parallel memory bus whose device latches the address when chip enable falls. Every access gets its own chip-enable low window of fixed length. A precharge interval with chip enable high follows each window, so chip enable never stays low across two addresses. All bus timing is counted in clock cycles set by parameters. The defaults assume a 20 ns clock: a 20 ns address setup, an 80 ns active window and a 60 ns precharge. After reset the bus stays idle until a power-up wait has run out.

Requests arrive on a valid/ready channel. `req_ready` is high only while the controller is idle and ready to start a new access. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. The requester must hold `req_valid` and its fields steady until then; this is the only back-pressure the block applies. The fields are captured at acceptance, so later changes on them do not matter. Read results come back as a one-cycle `rsp_valid` pulse with `rsp_data`. The response has no ready and cannot be stalled. The data bus is split into an output, an output enable and an input; the pad tristate joins them into one bidirectional bus.

Top module: `nvbus_host`

## Requirements
- R1: During reset and for PWRUP_CYC cycles after it, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `req_ready` is 0 and `rsp_valid` is 0. Chip enable first falls after that wait.
- R2: `req_ready` is 1 only while no access is in progress, and never while `mem_ce_n` is 0. A request held valid while ready is low is taken exactly once. Request fields that change after acceptance have no effect on the access.
- R3: Each accepted request makes exactly one chip-enable low window of ACTIVE_CYC cycles, never longer than ACTIVE_MAX_CYC. Chip enable is high for at least PRECHG_CYC cycles before every fall.
- R4: `mem_addr` carries the accepted address at least SETUP_CYC cycles before chip enable falls. It holds that address unchanged for the whole low window.
- R5: In a read, `mem_oe_n` is 0 exactly while chip enable is low, `mem_we_n` stays 1 and `mem_dq_oe` stays 0. `mem_dq_i` is sampled on the edge that ends the window. It is returned on `rsp_data` with a one-cycle `rsp_valid` pulse in the first cycle after chip enable rises. Reads return the value last written to that address, and 0 for an address never written.
- R6: In a write, `mem_we_n` falls at acceptance, before chip enable falls, and rises on the same edge as chip enable. `mem_oe_n` stays 1 throughout. `mem_dq_oe` is 1 with `mem_dq_o` equal to the write data for the whole low window, and output enable and write enable are never low together.
- R7: A write produces no `rsp_valid` pulse.
- R8: Requests presented back to back are accepted 1+SETUP_CYC+ACTIVE_CYC+PRECHG_CYC cycles apart (9 with the defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read completion pulse |
| rsp_data | output | DATA_W | Read data, valid with rsp_valid |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | ADDR_W | Bus address |
| mem_dq_o | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Host data driver enable |
| mem_dq_i | input | DATA_W | Data returned by the memory |

## Verification
The hardest case to reach is a request that arrives while the previous access is still in precharge. Here the minimum cycle spacing and the precharge floor must both hold on the same edge. The stimulus reaches it by issuing most random requests immediately after the previous acceptance, with `req_valid` held through the busy cycles. It then measures the acceptance spacing and the chip-enable high time before each fall. The memory model in the bench drives valid read data only after an access time has passed since chip enable fell, so any shortened active window returns a filler byte. The requests use a small pool of addresses that includes the all-zero and all-one addresses, so reads often follow writes to the same location.

// File: rtl/nvbus_pkg.sv
package nvbus_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_PRECHG
  } nvb_state_e;

endpackage

// File: rtl/nvbus_timer.sv
// Shared phase down-counter: a load sets the phase length, expired marks its last cycle.
module nvbus_timer #(
  parameter int W        = 6,
  parameter int RST_LOAD = 50
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= W'(RST_LOAD - 1);
    end else if (load) begin
      cnt_q <= load_val - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/nvbus_seq.sv
// Phase sequencer: power-up wait, idle, address setup, active window, precharge.
module nvbus_seq
  import nvbus_pkg::*;
#(
  parameter int W          = 6,
  parameter int SETUP_CYC  = 1,
  parameter int ACTIVE_CYC = 4,
  parameter int PRECHG_CYC = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         t_expired,
  output logic         req_ready,
  output logic         accept,
  output logic         end_active,
  output nvb_state_e   state_nx,
  output logic         t_load,
  output logic [W-1:0] t_val
);

  nvb_state_e state_q;

  always_comb begin
    state_nx = state_q;
    t_load   = 1'b0;
    t_val    = '0;
    unique case (state_q)
      ST_PWRUP: if (t_expired) state_nx = ST_IDLE;
      ST_IDLE: if (req_valid) begin
        state_nx = ST_SETUP;
        t_load   = 1'b1;
        t_val    = W'(SETUP_CYC);
      end
      ST_SETUP: if (t_expired) begin
        state_nx = ST_ACTIVE;
        t_load   = 1'b1;
        t_val    = W'(ACTIVE_CYC);
      end
      ST_ACTIVE: if (t_expired) begin
        state_nx = ST_PRECHG;
        t_load   = 1'b1;
        t_val    = W'(PRECHG_CYC);
      end
      ST_PRECHG: if (t_expired) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PWRUP;
    else        state_q <= state_nx;
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign end_active = (state_q == ST_ACTIVE) && t_expired;

  // R2
  accept_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state_q == ST_SETUP));

  // R3
  active_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_active |=> (state_q == ST_PRECHG));

endmodule

// File: rtl/nvbus_pins.sv
// Registered bus pins, captured request fields and read-data capture.
module nvbus_pins
  import nvbus_pkg::*;
#(
  parameter int ADDR_W         = 15,
  parameter int DATA_W         = 8,
  parameter int ACTIVE_CYC     = 4,
  parameter int ACTIVE_MAX_CYC = 100,
  parameter int PRECHG_CYC     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  nvb_state_e        state_nx,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              end_active,
  input  logic [DATA_W-1:0] dq_i,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  localparam int LO_W = $clog2(ACTIVE_MAX_CYC + 1);
  localparam int HI_W = $clog2(PRECHG_CYC + 1);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              wr_q, ce_n_q, we_n_q, oe_n_q, dq_oe_q, rsp_valid_q;
  logic              wr_sel, in_bus, in_strobe;

  assign wr_sel    = accept ? req_write : wr_q;
  assign in_bus    = state_nx inside {ST_SETUP, ST_ACTIVE, ST_PRECHG};
  assign in_strobe = state_nx inside {ST_SETUP, ST_ACTIVE};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      wdata_q     <= '0;
      wr_q        <= 1'b0;
      ce_n_q      <= 1'b1;
      we_n_q      <= 1'b1;
      oe_n_q      <= 1'b1;
      dq_oe_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        wr_q    <= req_write;
      end
      ce_n_q      <= (state_nx != ST_ACTIVE);
      we_n_q      <= !(wr_sel && in_strobe);
      oe_n_q      <= !(!wr_sel && (state_nx == ST_ACTIVE));
      dq_oe_q     <= wr_sel && in_bus;
      rsp_valid_q <= end_active && !wr_q;
      if (end_active && !wr_q) rdata_q <= dq_i;
    end
  end

  assign ce_n      = ce_n_q;
  assign we_n      = we_n_q;
  assign oe_n      = oe_n_q;
  assign addr      = addr_q;
  assign dq_o      = wdata_q;
  assign dq_oe     = dq_oe_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rdata_q;

  // Checker-side run-length counters of the chip-enable pin.
  logic [LO_W-1:0] lo_len;
  logic [HI_W-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_len <= '0;
      hi_len <= HI_W'(PRECHG_CYC);
    end else if (!ce_n_q) begin
      lo_len <= lo_len + 1'b1;
      hi_len <= '0;
    end else begin
      lo_len <= '0;
      if (hi_len != HI_W'(PRECHG_CYC)) hi_len <= hi_len + 1'b1;
    end
  end

  // R3
  ce_low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_n_q) |-> (lo_len == LO_W'(ACTIVE_CYC)));

  // R3
  ce_low_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n_q |-> (lo_len < LO_W'(ACTIVE_MAX_CYC)));

  // R3
  precharge_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_n_q) |-> (hi_len == HI_W'(PRECHG_CYC)));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n_q && $past(!ce_n_q)) |-> $stable(addr_q));

  // R6
  we_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ce_n_q) && !we_n_q) |-> $past(!we_n_q));

  // R6
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n_q && !we_n_q) && !(!oe_n_q && dq_oe_q));

  // R5
  rsp_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_q |-> ($past(!ce_n_q) && ce_n_q));

endmodule

// File: rtl/nvbus_host.sv
module nvbus_host
  import nvbus_pkg::*;
#(
  parameter int ADDR_W         = 15,
  parameter int DATA_W         = 8,
  parameter int PWRUP_CYC      = 50,
  parameter int SETUP_CYC      = 1,
  parameter int ACTIVE_CYC     = 4,
  parameter int ACTIVE_MAX_CYC = 100,
  parameter int PRECHG_CYC     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int MAX_PH = (PWRUP_CYC > ACTIVE_CYC) ?
                          ((PWRUP_CYC > PRECHG_CYC) ? PWRUP_CYC : PRECHG_CYC) :
                          ((ACTIVE_CYC > PRECHG_CYC) ? ACTIVE_CYC : PRECHG_CYC);
  localparam int MAX_ALL = (MAX_PH > SETUP_CYC) ? MAX_PH : SETUP_CYC;
  localparam int CNT_W   = $clog2(MAX_ALL + 1);
  localparam int PU_W    = $clog2(PWRUP_CYC + 1);

  logic             t_load, t_expired, accept, end_active, ready_w;
  logic [CNT_W-1:0] t_val;
  nvb_state_e       state_nx;

  nvbus_timer #(.W(CNT_W), .RST_LOAD(PWRUP_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  nvbus_seq #(
    .W(CNT_W), .SETUP_CYC(SETUP_CYC), .ACTIVE_CYC(ACTIVE_CYC), .PRECHG_CYC(PRECHG_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .t_expired  (t_expired),
    .req_ready  (ready_w),
    .accept     (accept),
    .end_active (end_active),
    .state_nx   (state_nx),
    .t_load     (t_load),
    .t_val      (t_val)
  );

  nvbus_pins #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACTIVE_CYC(ACTIVE_CYC),
    .ACTIVE_MAX_CYC(ACTIVE_MAX_CYC), .PRECHG_CYC(PRECHG_CYC)
  ) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_nx   (state_nx),
    .accept     (accept),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .end_active (end_active),
    .dq_i       (mem_dq_i),
    .ce_n       (mem_ce_n),
    .we_n       (mem_we_n),
    .oe_n       (mem_oe_n),
    .addr       (mem_addr),
    .dq_o       (mem_dq_o),
    .dq_oe      (mem_dq_oe),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );

  assign req_ready = ready_w;

  // Cycles since reset, saturating at the power-up wait.
  logic [PU_W-1:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             since_q <= '0;
    else if (since_q != PU_W'(PWRUP_CYC))   since_q <= since_q + 1'b1;
  end

  // R1
  pwrup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q < PU_W'(PWRUP_CYC)) |-> (mem_ce_n && !req_ready && !mem_dq_oe));

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

endmodule

// File: tb/test_nvbus_host.sv
module test_nvbus_host;

  localparam int PWRUP = 50, SETUP = 1, ACT = 4, ACTMAX = 100, PRE = 3;
  localparam int SPACING = 1 + SETUP + ACT + PRE;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_data;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq_o, mem_dq_i;

  nvbus_host #(
    .ADDR_W(15), .DATA_W(8), .PWRUP_CYC(PWRUP), .SETUP_CYC(SETUP),
    .ACTIVE_CYC(ACT), .ACTIVE_MAX_CYC(ACTMAX), .PRECHG_CYC(PRE)
  ) i_nvbus_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  always #10 clk = ~clk;

  int unsigned n_chk = 0, n_bad = 0;
  int unsigned cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // Memory device model: latches address at chip-enable fall, drives data after access time.
  logic [7:0]  dev_mem [int];
  logic [14:0] dev_lat = '0;
  int          dev_lo = 0;
  logic [7:0]  dq_drv = 8'hEE;
  assign mem_dq_i = dq_drv;

  always @(negedge clk) begin
    if (!mem_ce_n) begin
      if (dev_lo == 0) dev_lat = mem_addr;
      dev_lo++;
      if (!mem_we_n && mem_dq_oe) dev_mem[dev_lat] = mem_dq_o;
      // valid only once roughly 70 ns have passed since the fall
      if (!mem_oe_n && dev_lo >= 4)
        dq_drv = dev_mem.exists(dev_lat) ? dev_mem[dev_lat] : 8'h00;
      else
        dq_drv = 8'hEE;
    end else begin
      dev_lo = 0;
      dq_drv = 8'hEE;
    end
  end

  // Reference model
  logic [7:0]  ref_mem [int];
  logic [7:0]  exp_q [$];
  bit          cur_wr = 1'b0;
  logic [14:0] cur_addr = '0;
  logic [7:0]  cur_data = '0;
  int          last_acc = -1;

  function automatic logic [7:0] ref_read(input logic [14:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  // Pin monitor
  bit          prev_ce = 1'b1, prev_we = 1'b1, prev_rsp = 1'b0;
  logic [14:0] prev_addr = '0, win_addr = '0;
  int          hi_run = 1000, lo_run = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cyc < PWRUP) check(mem_ce_n && !req_ready && !mem_dq_oe, "R1", "quiet power-up",
                             {mem_ce_n, req_ready, mem_dq_oe}, 3'b100);
      if (prev_ce && !mem_ce_n) begin
        check(cyc > PWRUP, "R1", "first fall cycle", cyc, PWRUP);
        check(hi_run >= PRE, "R3", "precharge length", hi_run, PRE);
        check(prev_addr == cur_addr, "R4", "address setup", prev_addr, cur_addr);
        if (cur_wr) check(!prev_we, "R6", "we low before ce", prev_we, 0);
        win_addr = mem_addr;
        lo_run   = 0;
      end
      if (!prev_ce && mem_ce_n) begin
        check(lo_run == ACT, "R3", "window length", lo_run, ACT);
        check(mem_we_n, "R6", "we rises with ce", mem_we_n, 1);
        hi_run = 0;
      end
      if (!mem_ce_n) begin
        lo_run++;
        check(mem_addr == win_addr && mem_addr == cur_addr, "R4", "address hold",
              mem_addr, cur_addr);
        check(!req_ready, "R2", "ready while busy", req_ready, 0);
        if (cur_wr)
          check(mem_oe_n && !mem_we_n && mem_dq_oe && mem_dq_o == cur_data, "R6",
                "write pins", {mem_oe_n, mem_we_n, mem_dq_oe, mem_dq_o},
                {3'b101, cur_data});
        else
          check(!mem_oe_n && mem_we_n && !mem_dq_oe, "R5", "read pins",
                {mem_oe_n, mem_we_n, mem_dq_oe}, 3'b010);
      end else begin
        hi_run++;
        check(mem_oe_n, "R5", "oe only inside window", mem_oe_n, 1);
      end
      if (rsp_valid) begin
        check(!prev_ce && mem_ce_n, "R5", "response timing", {prev_ce, mem_ce_n}, 2'b01);
        check(!prev_rsp, "R5", "single-cycle pulse", prev_rsp, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "response with no read pending", rsp_data, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rsp_data == e, "R5", "read data", rsp_data, e);
        end
      end
      prev_ce   = mem_ce_n;
      prev_we   = mem_we_n;
      prev_addr = mem_addr;
      prev_rsp  = rsp_valid;
    end
  end

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d, input bit b2b);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    cur_wr = wr; cur_addr = a; cur_data = d;
    if (wr) ref_mem[a] = d;
    else    exp_q.push_back(ref_read(a));
    if (b2b && last_acc >= 0)
      check(int'(cyc) - last_acc == SPACING, "R8", "back-to-back spacing",
            int'(cyc) - last_acc, SPACING);
    last_acc = int'(cyc);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;              // R2: post-acceptance changes must not matter
    req_wdata = ~d;
    req_write = ~wr;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog: actual hang expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1808));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !req_ready && !rsp_valid,
          "R1", "reset pins", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid},
          6'b111000);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners: unwritten read, extreme addresses, back-to-back mix
    issue(1'b0, 15'h0000, 8'h00, 1'b0);
    issue(1'b1, 15'h7FFF, 8'hA5, 1'b1);
    issue(1'b0, 15'h7FFF, 8'h00, 1'b1);
    issue(1'b1, 15'h0000, 8'h3C, 1'b1);
    issue(1'b0, 15'h0000, 8'h00, 1'b1);
    issue(1'b0, 15'h7FFF, 8'h00, 1'b1);
    repeat (6) @(negedge clk);
    issue(1'b1, 15'h4000, 8'hFF, 1'b0);
    issue(1'b1, 15'h4000, 8'h00, 1'b1);
    issue(1'b0, 15'h4000, 8'h11, 1'b1);

    // Constrained random traffic over a small address pool
    for (int i = 0; i < 400; i++) begin
      bit          wr, b2b;
      logic [14:0] a;
      logic [7:0]  d;
      wr  = ($urandom % 2) == 1;
      a   = 15'(($urandom % 24) * 1367);
      d   = 8'($urandom);
      b2b = ($urandom % 3) != 0;
      if (!b2b) repeat (1 + $urandom % 4) @(negedge clk);
      issue(wr, a, d, b2b);
    end

    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, "R5", "reads left without response", exp_q.size(), 0);
    finish_run();
  end

endmodule